// File: doc/BRIEF.md
# Register Pending-Write Scoreboard

This block records, for each of the 32 integer registers of a five-stage in-order pipeline, whether a write to that register is still in flight. An instruction that leaves decode with a destination register sets that register's busy bit. The bit is cleared when write-back commits the value, or when the instruction is squashed by a flush while it sits in execute. Hazards are resolved only by stalling, because the pipeline has no forwarding network.

Three stages consult the table. Decode stalls when its destination is already busy, so two writes to the same register are never pending together. Execute and memory stall when a source operand they use is busy. Stalls propagate toward the front of the pipe. A memory stall also holds execute and decode, and an execute stall also holds decode. Each checking stage also gives the block its own destination. A stage's own pending write therefore never blocks its own reads, as in `add x5, x5, x1`. The execute stage's destination is also the mark that a flush removes.

Top module: `regbusy_sb`

## Requirements
- R1: While `rst` is high at a clock edge, all 32 busy bits are cleared on that edge.
- R2: When `dec_wr` is high, `dec_rd` is nonzero, `dec_stall` is low and `flush` is low, bit `dec_rd` of `busy` is 1 after the next clock edge.
- R3: Bit 0 of `busy` is always 0. A source or destination index of 0 never causes any stall.
- R4: `dec_stall` is high in the same cycle whenever `dec_wr` is high, `dec_rd` is nonzero and bit `dec_rd` of `busy` is set.
- R5: No bit is set while decode is held (`dec_stall` high) or while `flush` is high. A destination offered in such a cycle stays clear after the edge unless it was already set.
- R6: `ex_stall` is high when an execute source is flagged in use, is nonzero and is busy, unless that source equals the execute stage's own destination (`ex_wr` high and `ex_rd` equal).
- R7: `mem_stall` follows the same rule as R6, using the memory-stage sources and its own destination `mem_wr`/`mem_rd`.
- R8: `mem_stall` forces `ex_stall` and `dec_stall` high, and `ex_stall` forces `dec_stall` high.
- R9: A retire (`wb_wr` high, `wb_rd` nonzero) clears bit `wb_rd` on the next edge.
- R10: If a retire and a decode mark name the same register in one cycle, the bit is 1 after the edge.
- R11: On `flush`, the bit of the execute destination (`ex_wr`, `ex_rd`) is cleared on the next edge. Bits of other registers are not cleared by the flush.
- R12: A source whose use flag is low never causes a stall, whatever its index and busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_wr | input | 1 | Instruction in decode writes a destination |
| dec_rd | input | 5 | Decode destination index |
| ex_rs1_use | input | 1 | Execute uses source 1 |
| ex_rs1 | input | 5 | Execute source 1 index |
| ex_rs2_use | input | 1 | Execute uses source 2 |
| ex_rs2 | input | 5 | Execute source 2 index |
| ex_wr | input | 1 | Instruction in execute writes a destination |
| ex_rd | input | 5 | Execute destination index |
| mem_rs1_use | input | 1 | Memory stage uses source 1 |
| mem_rs1 | input | 5 | Memory source 1 index |
| mem_rs2_use | input | 1 | Memory stage uses source 2 |
| mem_rs2 | input | 5 | Memory source 2 index |
| mem_wr | input | 1 | Instruction in memory writes a destination |
| mem_rd | input | 5 | Memory destination index |
| wb_wr | input | 1 | Write-back commits a register this cycle |
| wb_rd | input | 5 | Write-back destination index |
| flush | input | 1 | Squash decode and execute instructions |
| dec_stall | output | 1 | Hold decode |
| ex_stall | output | 1 | Hold execute |
| mem_stall | output | 1 | Hold memory stage |
| busy | output | 32 | Pending-write bit per register |

## Verification
All three stall outputs are combinational from the registered busy vector and the current inputs. They are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and compares the stalls one time step later. Every change to `busy` (mark, retire, flush and reset) is due one rising edge after the stimulus. The bench updates its reference vector at that rising edge and compares `busy` at the following falling edge, before it applies new inputs.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_NREGS = 32;
    localparam int SB_IDXW  = $clog2(SB_NREGS);
    localparam int SB_NSRC  = 2;

    typedef logic [SB_IDXW-1:0]  ridx_t;
    typedef logic [SB_NREGS-1:0] rvec_t;

    typedef struct packed {
        logic  en;
        ridx_t idx;
    } src_t;

    typedef struct packed {
        logic  wr;
        ridx_t idx;
    } dst_t;

    // One-hot select of a register; index 0 never selected
    function automatic rvec_t sel_vec(input logic en, input ridx_t idx);
        rvec_t v;
        v = '0;
        if (en && (idx != '0)) v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/sb_busy_table.sv
module sb_busy_table
    import sb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  dst_t  set_req,
    input  dst_t  clr_ret,
    input  dst_t  clr_sq,
    output rvec_t busy
);
    rvec_t nxt;

    // Clears first, then the set, so a same-cycle mark wins
    always_comb begin
        nxt = busy;
        nxt = nxt & ~sel_vec(clr_ret.wr, clr_ret.idx);
        nxt = nxt & ~sel_vec(clr_sq.wr, clr_sq.idx);
        nxt = nxt | sel_vec(set_req.wr, set_req.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= nxt;
    end
endmodule

// File: rtl/sb_src_check.sv
module sb_src_check
    import sb_pkg::*;
#(
    parameter int NSRC = SB_NSRC
) (
    input  src_t [NSRC-1:0] srcs,
    input  dst_t            own,
    input  rvec_t           busy,
    output logic            hit
);
    logic [NSRC-1:0] per_src;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic is_own;
        assign is_own     = own.wr && (own.idx == srcs[g].idx);
        assign per_src[g] = srcs[g].en && (srcs[g].idx != '0)
                            && busy[srcs[g].idx] && !is_own;
    end

    assign hit = |per_src;
endmodule

// File: rtl/sb_dec_gate.sv
module sb_dec_gate
    import sb_pkg::*;
(
    input  dst_t  req,
    input  rvec_t busy,
    input  logic  hold,
    input  logic  flush,
    output logic  conflict,
    output dst_t  mark
);
    assign conflict = req.wr && (req.idx != '0) && busy[req.idx];
    assign mark.wr  = req.wr && !conflict && !hold && !flush;
    assign mark.idx = req.idx;
endmodule

// File: rtl/regbusy_sb.sv
module regbusy_sb
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dec_wr,
    input  logic [SB_IDXW-1:0]  dec_rd,
    input  logic                ex_rs1_use,
    input  logic [SB_IDXW-1:0]  ex_rs1,
    input  logic                ex_rs2_use,
    input  logic [SB_IDXW-1:0]  ex_rs2,
    input  logic                ex_wr,
    input  logic [SB_IDXW-1:0]  ex_rd,
    input  logic                mem_rs1_use,
    input  logic [SB_IDXW-1:0]  mem_rs1,
    input  logic                mem_rs2_use,
    input  logic [SB_IDXW-1:0]  mem_rs2,
    input  logic                mem_wr,
    input  logic [SB_IDXW-1:0]  mem_rd,
    input  logic                wb_wr,
    input  logic [SB_IDXW-1:0]  wb_rd,
    input  logic                flush,
    output logic                dec_stall,
    output logic                ex_stall,
    output logic                mem_stall,
    output logic [SB_NREGS-1:0] busy
);
    src_t [SB_NSRC-1:0] ex_srcs, mem_srcs;
    dst_t ex_own, mem_own, dec_req, dec_mark, ret_dst, sq_dst;
    rvec_t busy_q;
    logic ex_hit, mem_hit, dec_conflict;

    assign ex_srcs[0]  = '{en: ex_rs1_use,  idx: ex_rs1};
    assign ex_srcs[1]  = '{en: ex_rs2_use,  idx: ex_rs2};
    assign mem_srcs[0] = '{en: mem_rs1_use, idx: mem_rs1};
    assign mem_srcs[1] = '{en: mem_rs2_use, idx: mem_rs2};
    assign ex_own      = '{wr: ex_wr,  idx: ex_rd};
    assign mem_own     = '{wr: mem_wr, idx: mem_rd};
    assign dec_req     = '{wr: dec_wr, idx: dec_rd};
    assign ret_dst     = '{wr: wb_wr,  idx: wb_rd};
    assign sq_dst      = '{wr: flush && ex_wr, idx: ex_rd};

    sb_src_check #(.NSRC(SB_NSRC)) u_ex_chk (
        .srcs(ex_srcs), .own(ex_own), .busy(busy_q), .hit(ex_hit)
    );

    sb_src_check #(.NSRC(SB_NSRC)) u_mem_chk (
        .srcs(mem_srcs), .own(mem_own), .busy(busy_q), .hit(mem_hit)
    );

    // Stalls propagate toward the front of the pipe
    assign mem_stall = mem_hit;
    assign ex_stall  = ex_hit || mem_stall;

    sb_dec_gate u_dec (
        .req(dec_req), .busy(busy_q), .hold(ex_stall), .flush(flush),
        .conflict(dec_conflict), .mark(dec_mark)
    );

    assign dec_stall = dec_conflict || ex_stall;

    sb_busy_table u_tbl (
        .clk(clk), .rst(rst), .set_req(dec_mark),
        .clr_ret(ret_dst), .clr_sq(sq_dst), .busy(busy_q)
    );

    assign busy = busy_q;
endmodule

// File: rtl/regbusy_sb_chk.sv
module regbusy_sb_chk
    import sb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                dec_wr,
    input logic [SB_IDXW-1:0]  dec_rd,
    input logic                ex_rs1_use,
    input logic [SB_IDXW-1:0]  ex_rs1,
    input logic                ex_rs2_use,
    input logic [SB_IDXW-1:0]  ex_rs2,
    input logic                ex_wr,
    input logic [SB_IDXW-1:0]  ex_rd,
    input logic                mem_rs1_use,
    input logic [SB_IDXW-1:0]  mem_rs1,
    input logic                mem_rs2_use,
    input logic [SB_IDXW-1:0]  mem_rs2,
    input logic                mem_wr,
    input logic [SB_IDXW-1:0]  mem_rd,
    input logic                wb_wr,
    input logic [SB_IDXW-1:0]  wb_rd,
    input logic                flush,
    input logic                dec_stall,
    input logic                ex_stall,
    input logic                mem_stall,
    input logic [SB_NREGS-1:0] busy
);
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    a_r1_reset_clears: assert property (@(posedge clk)
        started && rst |=> busy == '0);

    a_r3_x0_free: assert property (@(posedge clk) disable iff (rst)
        started |-> !busy[0]);

    a_r2_mark_sets: assert property (@(posedge clk) disable iff (rst)
        dec_wr && dec_rd != '0 && !dec_stall && !flush |=> busy[$past(dec_rd)]);

    a_r4_double_write: assert property (@(posedge clk) disable iff (rst)
        dec_wr && dec_rd != '0 && busy[dec_rd] |-> dec_stall);

    a_r5_no_mark_held: assert property (@(posedge clk) disable iff (rst)
        (dec_stall || flush) && dec_wr && !busy[dec_rd] |=> !busy[$past(dec_rd)]);

    a_r6_ex_raw: assert property (@(posedge clk) disable iff (rst)
        ex_rs1_use && ex_rs1 != '0 && busy[ex_rs1] && !(ex_wr && ex_rd == ex_rs1)
        |-> ex_stall);

    a_r7_mem_raw: assert property (@(posedge clk) disable iff (rst)
        mem_rs2_use && mem_rs2 != '0 && busy[mem_rs2] && !(mem_wr && mem_rd == mem_rs2)
        |-> mem_stall);

    a_r8_stall_chain: assert property (@(posedge clk) disable iff (rst)
        mem_stall |-> ex_stall && dec_stall);

    a_r9_retire_clears: assert property (@(posedge clk) disable iff (rst)
        wb_wr && !(dec_wr && !dec_stall && !flush && dec_rd == wb_rd)
        |=> !busy[$past(wb_rd)]);

    a_r11_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush && ex_wr |=> !busy[$past(ex_rd)]);

    a_r12_unused_src: assert property (@(posedge clk) disable iff (rst)
        !ex_rs1_use && !ex_rs2_use && !mem_rs1_use && !mem_rs2_use |-> !ex_stall);
endmodule

bind regbusy_sb regbusy_sb_chk chk_i (.*);

// File: tb/regbusy_sb_tb_top.sv
`timescale 1ns/1ps
module regbusy_sb_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic dec_wr, ex_rs1_use, ex_rs2_use, ex_wr, mem_rs1_use, mem_rs2_use;
    logic mem_wr, wb_wr, flush;
    logic [4:0] dec_rd, ex_rs1, ex_rs2, ex_rd, mem_rs1, mem_rs2, mem_rd, wb_rd;
    logic dec_stall, ex_stall, mem_stall;
    logic [31:0] busy;
    logic [31:0] mbusy;
    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    regbusy_sb dut_i (.*);

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        report();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic hit(logic u, logic [4:0] s, logic ow, logic [4:0] od);
        return u && s != 0 && mbusy[s] && !(ow && od == s);
    endfunction

    function automatic logic e_mem();
        return hit(mem_rs1_use, mem_rs1, mem_wr, mem_rd) || hit(mem_rs2_use, mem_rs2, mem_wr, mem_rd);
    endfunction
    function automatic logic e_ex();
        return hit(ex_rs1_use, ex_rs1, ex_wr, ex_rd) || hit(ex_rs2_use, ex_rs2, ex_wr, ex_rd) || e_mem();
    endfunction
    function automatic logic e_dec();
        return (dec_wr && dec_rd != 0 && mbusy[dec_rd]) || e_ex();
    endfunction

    function automatic logic [31:0] e_next();
        logic [31:0] n;
        n = mbusy;
        if (wb_wr) n[wb_rd] = 1'b0;
        if (flush && ex_wr) n[ex_rd] = 1'b0;
        if (dec_wr && !e_dec() && !flush) n[dec_rd] = 1'b1;
        n[0] = 1'b0;
        return n;
    endfunction

    task automatic idle;
        {dec_wr, ex_rs1_use, ex_rs2_use, ex_wr, mem_rs1_use, mem_rs2_use, mem_wr, wb_wr, flush} = '0;
        {dec_rd, ex_rs1, ex_rs2, ex_rd, mem_rs1, mem_rs2, mem_rd, wb_rd} = '0;
    endtask

    // Inputs already driven after a falling edge
    task automatic step(string sreq, string breq);
        logic [31:0] nx;
        #1;
        chk({sreq, " mem_stall"}, 32'(mem_stall), 32'(e_mem()));
        chk({sreq, " ex_stall"},  32'(ex_stall),  32'(e_ex()));
        chk({sreq, " dec_stall"}, 32'(dec_stall), 32'(e_dec()));
        nx = e_next();
        @(posedge clk);
        mbusy = rst ? 32'h0 : nx;
        @(negedge clk);
        chk(breq, busy, mbusy);
    endtask

    task automatic do_reset;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mbusy = '0;
        chk("R1 reset clears busy", busy, 32'h0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        idle();
        @(negedge clk);
        do_reset();

        // R2: mark x5
        dec_wr = 1; dec_rd = 5;
        step("R2", "R2 mark sets bit");
        // R4: second write to x5 stalls decode
        idle(); dec_wr = 1; dec_rd = 5;
        step("R4 double write", "R4 bit kept");
        // R5: x6 offered while execute stalls on x5
        idle(); dec_wr = 1; dec_rd = 6; ex_rs1_use = 1; ex_rs1 = 5;
        step("R5 R6 held", "R5 no mark while held");
        chk("R5 x6 clear", 32'(busy[6]), 32'd0);
        // R3: x0 mark and read
        idle(); dec_wr = 1; dec_rd = 0; ex_rs1_use = 1; ex_rs1 = 0; mem_rs2_use = 1;
        step("R3 x0 never stalls", "R3 x0 never busy");
        // R6: own destination excluded
        idle(); ex_rs1_use = 1; ex_rs1 = 5; ex_wr = 1; ex_rd = 5;
        step("R6 own dest", "R6 busy");
        chk("R6 no stall on own dest", 32'(ex_stall), 32'd0);
        // R7 R8: memory hit drives all stalls
        idle(); mem_rs2_use = 1; mem_rs2 = 5;
        step("R7 R8 mem hit", "R7 busy");
        chk("R8 chain", {29'd0, mem_stall, ex_stall, dec_stall}, 32'd7);
        // R12: index busy but unused
        idle(); ex_rs1 = 5; ex_rs2 = 5; mem_rs1 = 5; mem_rs2 = 5;
        step("R12 unused", "R12 busy");
        chk("R12 no stall", {29'd0, mem_stall, ex_stall, dec_stall}, 32'd0);
        // R10: retire and re-mark x5 cannot both: x5 busy stalls decode; use x7
        idle(); dec_wr = 1; dec_rd = 7;
        step("R2", "R2 mark x7");
        idle(); wb_wr = 1; wb_rd = 5;
        step("R9", "R9 retire x5");
        chk("R9 x5 cleared", 32'(busy[5]), 32'd0);
        idle(); dec_wr = 1; dec_rd = 5; wb_wr = 1; wb_rd = 5;
        step("R10", "R10 mark wins");
        chk("R10 x5 set", 32'(busy[5]), 32'd1);
        // R11: flush clears execute dest x7, keeps x5, suppresses mark of x9
        idle(); flush = 1; ex_wr = 1; ex_rd = 7; mem_wr = 1; mem_rd = 5; dec_wr = 1; dec_rd = 9;
        step("R11 flush", "R11 flush clear");
        chk("R11 x7/x5/x9", {29'd0, busy[9], busy[7], busy[5]}, 32'd1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            dec_wr = ($urandom_range(0, 2) != 0); dec_rd = 5'($urandom_range(0, 9));
            ex_rs1_use = $urandom_range(0, 1); ex_rs1 = 5'($urandom_range(0, 9));
            ex_rs2_use = $urandom_range(0, 1); ex_rs2 = 5'($urandom_range(0, 9));
            ex_wr = $urandom_range(0, 1); ex_rd = 5'($urandom_range(0, 9));
            mem_rs1_use = ($urandom_range(0, 3) == 0); mem_rs1 = 5'($urandom_range(0, 9));
            mem_rs2_use = ($urandom_range(0, 3) == 0); mem_rs2 = 5'($urandom_range(0, 9));
            mem_wr = $urandom_range(0, 1); mem_rd = 5'($urandom_range(0, 9));
            wb_wr = ($urandom_range(0, 1) == 0); wb_rd = 5'($urandom_range(0, 9));
            flush = ($urandom_range(0, 15) == 0);
            step("R4 R6 R7 R8 R12 random", "R2 R5 R9 R10 R11 random busy");
            if (i == 2000) do_reset();
        end
        idle();
        report();
    end
endmodule